// File: doc/BRIEF.md
# Manchester Line Receiver with Pulse-Width Squelch

This block sits behind the line slicer of a 10 Mb/s Ethernet port. It takes the already-sliced line level, sampled by a clock running at `OVS` samples per bit cell. Before raising carrier sense, it screens the line with a digital pulse-width squelch. It then locks onto the bit-cell phase by following mid-cell transitions and decodes Manchester symbols into NRZ data, which it presents with a recovered receive clock.

Data is withheld while the decoder settles. The settling time is short in attachment-unit mode and longer in twisted-pair mode. Whenever no decoded data is being delivered, the receive clock output is taken from the local transmit clock. The sliced line is expected to rest low between frames, and every frame is expected to open with an alternating preamble whose first bit is 1.

Top module: `manchester_rx`

## Requirements
- R1: After reset, `crs_n_o` reads 1 and `rx_clk_o` equals `tx_clk_i`.
- R2: A single high pulse on `line_i` lasting fewer than `SQ_MIN` samples (default 3) leaves `crs_n_o` at 1.
- R3: A transition ending a level run of `SQ_MIN` to `2*OVS` samples (defaults 3 to 24) drives `crs_n_o` to 0. A transition ending a longer run, such as the first one after an idle line, does not. A pulse of `2*OVS+1` samples is therefore rejected.
- R4: Decoding follows the mid-cell transition of each bit. Low-to-high gives `rxd_o` = 1 and high-to-low gives 0. Cell-boundary transitions produce no bit. Each delivered bit is valid on a rising edge of `rx_clk_o` half a cell after its mid-cell transition.
- R5: Carrier sense stays asserted for at least 1.5 bit times after the last mid-cell transition. It returns to 1 once no mid-cell transition has been seen for `2*OVS` samples, and no later than 2 bit times plus 8 samples after the last cell ends.
- R6: In twisted-pair mode (`aui_mode_i` = 0) the first `LOCK_TP` (default 8) bits decoded after carrier sense asserts are withheld. Exactly `n-1-LOCK_TP` rising edges of `rx_clk_o` occur while carrier sense is asserted for an `n`-bit frame. The first of them comes within `LOCK_TP+1` bit times of carrier assertion.
- R7: In attachment-unit mode (`aui_mode_i` = 1) the same holds with `LOCK_AUI` (default 4) in place of `LOCK_TP`.
- R8: `aui_mode_i` is sampled when carrier sense asserts. Changing it during a frame does not alter that frame's withheld count.
- R9: While carrier sense is deasserted, before data release and after a frame ends, `rx_clk_o` equals `tx_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, `OVS` samples per bit cell |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Sliced line level, resting low when idle |
| tx_clk_i | input | 1 | Local transmit clock, passed through when no data is delivered |
| aui_mode_i | input | 1 | 1 selects attachment-unit settling time, 0 twisted-pair |
| crs_n_o | output | 1 | Carrier sense, active low |
| rxd_o | output | 1 | Decoded NRZ data |
| rx_clk_o | output | 1 | Receive clock: recovered while delivering data, else `tx_clk_i` |

## Verification
A wrong bit-cell phase shows up at once as inverted or missing bits on `rxd_o`. It also shows as a released bit count that differs from `n-1-LOCK` by the end of the frame. A run-length counter that is off by one shows only at the squelch boundaries. That is why pulses of exactly `SQ_MIN-1`, `SQ_MIN`, `2*OVS` and `2*OVS+1` samples are driven one at a time, each followed by a long quiet line. A state machine stuck in carrier appears within about three bit times as `crs_n_o` staying low after the line goes quiet, or as `rx_clk_o` failing to follow `tx_clk_i`.

// File: rtl/mrx_pkg.sv
// Shared types and helpers for the Manchester receiver.
// Assumes nothing beyond IEEE 1800-2017 elaboration.
package mrx_pkg;

    // Receive sequencer states: quiet line, settling, delivering data
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ACQ  = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

    // Larger of two integers, used to size shared counters
    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/mrx_squelch.sv
// Line synchroniser, transition detector and pulse-width squelch.
// Measures the length of each level run between two transitions. A
// transition qualifies when the run it ends lies in [SQ_MIN, RUN_SAT-1]
// samples. Assumes line_i rests low after reset.
module mrx_squelch #(
    parameter int SYNC_STAGES = 2,
    parameter int SQ_MIN      = 3,
    parameter int RUN_SAT     = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic edge_o,
    output logic accept_o
);
    localparam int RUN_W = $clog2(RUN_SAT + 1);
    localparam logic [RUN_W-1:0] SAT_V  = RUN_W'(RUN_SAT);
    localparam logic [RUN_W-1:0] MIN_V  = RUN_W'(SQ_MIN);
    localparam logic [RUN_W-1:0] ONE_V  = RUN_W'(1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level_q;
    logic [RUN_W-1:0]       run_q;

    genvar gi;
    generate
        for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
            if (gi == 0) begin : g_first
                // First synchroniser stage captures the raw line
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= line_i;
                end
            end else begin : g_next
                // Further stages settle metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[gi] <= 1'b0;
                    else        sync_q[gi] <= sync_q[gi-1];
                end
            end
        end
    endgenerate

    // Transition detect and pulse qualification on the settled level
    always_comb begin
        level_o  = sync_q[SYNC_STAGES-1];
        edge_o   = level_o ^ level_q;
        accept_o = edge_o && (run_q >= MIN_V) && (run_q < SAT_V);
    end

    // Previous settled level and saturating run-length counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            run_q   <= SAT_V;
        end else begin
            level_q <= level_o;
            if (edge_o)              run_q <= ONE_V;
            else if (run_q < SAT_V)  run_q <= run_q + ONE_V;
        end
    end

    generate
        if (SQ_MIN >= 2) begin : g_sq_chk
            // R2
            no_back_to_back_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
                accept_o |=> !accept_o);
        end
    endgenerate

endmodule

// File: rtl/mrx_cell_timer.sv
// Bit-cell phase tracker. Counts samples since the last mid-cell
// transition. While not tracking, every transition restarts the cell.
// While tracking, only transitions at least 3/4 of a cell after the last
// one count as mid-cell. Produces the recovered clock (low for the first
// half cell) and an end-of-frame timeout after 2*OVS quiet samples.
// Assumes OVS is even and at least 4.
module mrx_cell_timer #(
    parameter int OVS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic tracking_i,
    output logic mid_o,
    output logic timeout_o,
    output logic rec_clk_o
);
    localparam int IDLE_LIM = 2 * OVS;
    localparam int HALF     = OVS / 2;
    localparam int MID_MIN  = (3 * OVS) / 4;
    localparam int POS_W    = $clog2(IDLE_LIM + 1);
    localparam logic [POS_W-1:0] LIM_V  = POS_W'(IDLE_LIM);
    localparam logic [POS_W-1:0] HALF_V = POS_W'(HALF);
    localparam logic [POS_W-1:0] MID_V  = POS_W'(MID_MIN);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nxt;
    logic             rec_q;

    // Classify the current transition and compute the next cell position
    always_comb begin
        mid_o     = edge_i && (!tracking_i || (pos_q >= MID_V));
        timeout_o = (pos_q >= LIM_V);
        if (mid_o)              pos_nxt = '0;
        else if (pos_q < LIM_V) pos_nxt = pos_q + POS_W'(1);
        else                    pos_nxt = pos_q;
        rec_clk_o = rec_q;
    end

    // Cell position counter and registered recovered clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= LIM_V;
            rec_q <= 1'b1;
        end else begin
            pos_q <= pos_nxt;
            rec_q <= (pos_nxt >= HALF_V);
        end
    end

    // R5
    timeout_not_after_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> !$past(edge_i));

endmodule

// File: rtl/mrx_frame_ctrl.sv
// Receive sequencer. Raises carrier on a qualified pulse, counts decoded
// bits while settling, then delivers each mid-cell level as NRZ data.
// Drops carrier on the end-of-frame timeout. The settling length is
// latched from the mode input when carrier rises.
module mrx_frame_ctrl
    import mrx_pkg::*;
#(
    parameter int LOCK_TP  = 8,
    parameter int LOCK_AUI = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    input  logic mid_i,
    input  logic timeout_i,
    input  logic level_i,
    input  logic aui_mode_i,
    output logic crs_n_o,
    output logic sel_o,
    output logic tracking_o,
    output logic rxd_o
);
    localparam int CNT_MAX = max2(LOCK_TP, LOCK_AUI);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] CMAX_V = CNT_W'(CNT_MAX);
    localparam logic [CNT_W-1:0] TP_V   = CNT_W'(LOCK_TP);
    localparam logic [CNT_W-1:0] AUI_V  = CNT_W'(LOCK_AUI);

    rx_state_e        state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lock_lim_q;
    logic             rxd_q;

    // Output decode from the sequencer state
    always_comb begin
        crs_n_o    = (state_q == RX_IDLE);
        tracking_o = (state_q != RX_IDLE);
        sel_o      = (state_q == RX_DATA);
        rxd_o      = rxd_q;
    end

    // Sequencer, decoded-bit counter and data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= RX_IDLE;
            cnt_q      <= '0;
            lock_lim_q <= TP_V;
            rxd_q      <= 1'b0;
        end else begin
            unique case (state_q)
                RX_IDLE: begin
                    if (accept_i) begin
                        state_q    <= RX_ACQ;
                        cnt_q      <= CNT_W'(1);
                        lock_lim_q <= aui_mode_i ? AUI_V : TP_V;
                    end
                end
                default: begin
                    if (timeout_i) begin
                        state_q <= RX_IDLE;
                        cnt_q   <= '0;
                        rxd_q   <= 1'b0;
                    end else if (mid_i) begin
                        if (cnt_q >= lock_lim_q) begin
                            state_q <= RX_DATA;
                            rxd_q   <= level_i;
                        end
                        if (cnt_q < CMAX_V) cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // R3
    carrier_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(crs_n_o) |-> $past(accept_i));

    // R5
    carrier_drop_needs_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crs_n_o) |-> $past(timeout_i));

    // R4
    rxd_moves_on_cell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rxd_o) |-> $past(mid_i || timeout_i));

    // R6
    release_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_o |-> (cnt_q >= lock_lim_q));

    // R9
    release_on_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> $past(mid_i));

endmodule

// File: rtl/mrx_clk_sel.sv
// Receive clock source selector. Passes the recovered clock while data
// is delivered and the local transmit clock otherwise. The select only
// rises on a mid-cell transition, when the recovered clock is low.
module mrx_clk_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_i,
    input  logic carrier_i,
    input  logic rec_clk_i,
    input  logic tx_clk_i,
    output logic rx_clk_o
);
    // Clock source multiplexer
    always_comb begin
        rx_clk_o = sel_i ? rec_clk_i : tx_clk_i;
    end

    // R9
    idle_clock_is_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier_i |-> (rx_clk_o == tx_clk_i));

endmodule

// File: rtl/manchester_rx.sv
// Top of the Manchester receiver: squelch, cell timer, sequencer and
// clock selector. Assumes clk runs at OVS samples per bit, the line rests
// low when idle and frames open with a 1,0 preamble.
module manchester_rx #(
    parameter int OVS         = 12,
    parameter int SQ_MIN      = 3,
    parameter int LOCK_TP     = 8,
    parameter int LOCK_AUI    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic tx_clk_i,
    input  logic aui_mode_i,
    output logic crs_n_o,
    output logic rxd_o,
    output logic rx_clk_o
);
    localparam int RUN_SAT = 2 * OVS + 1;

    logic level_w;
    logic edge_w;
    logic accept_w;
    logic mid_w;
    logic timeout_w;
    logic rec_clk_w;
    logic tracking_w;
    logic sel_w;
    logic crs_n_w;

    mrx_squelch #(
        .SYNC_STAGES (SYNC_STAGES),
        .SQ_MIN      (SQ_MIN),
        .RUN_SAT     (RUN_SAT)
    ) u_squelch (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_i   (line_i),
        .level_o  (level_w),
        .edge_o   (edge_w),
        .accept_o (accept_w)
    );

    mrx_cell_timer #(
        .OVS (OVS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .edge_i     (edge_w),
        .tracking_i (tracking_w),
        .mid_o      (mid_w),
        .timeout_o  (timeout_w),
        .rec_clk_o  (rec_clk_w)
    );

    mrx_frame_ctrl #(
        .LOCK_TP  (LOCK_TP),
        .LOCK_AUI (LOCK_AUI)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept_w),
        .mid_i      (mid_w),
        .timeout_i  (timeout_w),
        .level_i    (level_w),
        .aui_mode_i (aui_mode_i),
        .crs_n_o    (crs_n_w),
        .sel_o      (sel_w),
        .tracking_o (tracking_w),
        .rxd_o      (rxd_o)
    );

    mrx_clk_sel u_clksel (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel_w),
        .carrier_i (~crs_n_w),
        .rec_clk_i (rec_clk_w),
        .tx_clk_i  (tx_clk_i),
        .rx_clk_o  (rx_clk_o)
    );

    // Carrier sense to the port
    always_comb begin
        crs_n_o = crs_n_w;
    end

endmodule

// File: tb/manchester_rx_tb.sv
module manchester_rx_tb;
    localparam int OVS      = 12;
    localparam int HALF     = OVS / 2;
    localparam int SQ_MIN   = 3;
    localparam int LOCK_TP  = 8;
    localparam int LOCK_AUI = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_i = 1'b0;
    logic tx_clk_i = 1'b0;
    logic aui_mode_i = 1'b0;
    logic crs_n_o;
    logic rxd_o;
    logic rx_clk_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int cyc = 0;
    logic cap_bits [0:1023];
    int   cap_cyc  [0:1023];
    int   ncap = 0;
    int   crs_fall_cyc = 0;

    manchester_rx #(
        .OVS(OVS), .SQ_MIN(SQ_MIN), .LOCK_TP(LOCK_TP), .LOCK_AUI(LOCK_AUI), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .tx_clk_i(tx_clk_i),
        .aui_mode_i(aui_mode_i), .crs_n_o(crs_n_o), .rxd_o(rxd_o), .rx_clk_o(rx_clk_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Capture delivered bits on rising receive clock while carrier is up
    always @(posedge rx_clk_o) begin
        if (crs_n_o === 1'b0 && ncap < 1024) begin
            cap_bits[ncap] = rxd_o;
            cap_cyc[ncap]  = cyc;
            ncap++;
        end
    end

    always @(negedge crs_n_o) crs_fall_cyc = cyc;

    function automatic int lock_of(input bit aui);
        return aui ? LOCK_AUI : LOCK_TP;
    endfunction

    function automatic int exp_count(input int n, input bit aui);
        return n - 1 - lock_of(aui);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int c);
        line_i = v;
        repeat (c) @(negedge clk);
    endtask

    task automatic follow_check(input string tag);
        int bad = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            tx_clk_i = ~tx_clk_i;
            #1;
            if (rx_clk_o !== tx_clk_i) bad++;
        end
        check(bad == 0, tag, "rx clock samples differing from tx clock", bad, 0);
    endtask

    // Drive one high pulse of given width and report whether carrier rose
    task automatic pulse_probe(input int width, output bit seen);
        seen = 1'b0;
        line_i = 1'b1;
        for (int k = 0; k < width; k++) begin
            @(negedge clk);
            if (crs_n_o == 1'b0) seen = 1'b1;
        end
        line_i = 1'b0;
        for (int k = 0; k < 3 * OVS; k++) begin
            @(negedge clk);
            if (crs_n_o == 1'b0) seen = 1'b1;
        end
        repeat (2 * OVS) @(negedge clk);
    endtask

    task automatic run_frame(input int n, input bit aui, input bit flip,
                             input int pat, input string tag);
        logic [63:0] b;
        int base;
        int got;
        int mism;
        int lat;
        int lk;
        mism = 0;
        lk = lock_of(aui);
        if (pat == 1)      b = '1;
        else if (pat == 2) b = '0;
        else               b = {$urandom, $urandom};
        b[0] = 1'b1;
        b[1] = 1'b0;
        aui_mode_i = aui;
        base = ncap;
        for (int i = 0; i < n; i++) begin
            hold(~b[i], HALF);
            hold(b[i], HALF);
            if (i == 0) check(crs_n_o == 1'b1, "R3", "carrier after lone first transition", crs_n_o, 1);
            if (i == 2) check(crs_n_o == 1'b0, "R3", "carrier after preamble pulse", crs_n_o, 0);
            if (i == 4 && flip) aui_mode_i = ~aui;
        end
        repeat (OVS) @(negedge clk);
        check(crs_n_o == 1'b0, "R5", "carrier 1.5 bits after last mid-cell", crs_n_o, 0);
        repeat (OVS + 8) @(negedge clk);
        check(crs_n_o == 1'b1, "R5", "carrier after quiet line", crs_n_o, 1);
        got = ncap - base;
        check(got == exp_count(n, aui), tag, "delivered bit count", got, exp_count(n, aui));
        for (int i = 0; i < got; i++)
            if (i + lk + 1 < 64 && cap_bits[base + i] !== b[i + lk + 1]) mism++;
        check(mism == 0, "R4", "decoded bits differing from sent", mism, 0);
        if (got > 0) begin
            lat = cap_cyc[base] - crs_fall_cyc;
            check(lat <= (lk + 1) * OVS, tag, "cycles from carrier to first delivered bit",
                  lat, (lk + 1) * OVS);
        end
        aui_mode_i = 1'b0;
        hold(1'b0, 3 * OVS);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements): actual hung run expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        bit seen;
        int w;
        seed = $urandom(32'h5EED_0042);
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(crs_n_o == 1'b1, "R1", "carrier after reset", crs_n_o, 1);
        follow_check("R1");

        // R2 random short glitches, well separated
        for (int g = 0; g < 6; g++) begin
            w = 1 + int'($urandom % (SQ_MIN - 1));
            pulse_probe(w, seen);
            check(!seen, "R2", "carrier on short glitch", seen, 0);
        end
        pulse_probe(SQ_MIN - 1, seen);
        check(!seen, "R2", "carrier on pulse of SQ_MIN-1 samples", seen, 0);

        // R3 squelch boundaries
        pulse_probe(SQ_MIN, seen);
        check(seen, "R3", "carrier on pulse of SQ_MIN samples", seen, 1);
        pulse_probe(2 * OVS, seen);
        check(seen, "R3", "carrier on pulse of 2*OVS samples", seen, 1);
        pulse_probe(2 * OVS + 1, seen);
        check(!seen, "R3", "carrier on pulse of 2*OVS+1 samples", seen, 0);
        follow_check("R9");

        // R6 / R7 random frames in both modes, R4 directed patterns
        for (int f = 0; f < 5; f++) run_frame(16 + int'($urandom % 25), 1'b0, 1'b0, 0, "R6");
        for (int f = 0; f < 5; f++) run_frame(16 + int'($urandom % 25), 1'b1, 1'b0, 0, "R7");
        run_frame(30, 1'b0, 1'b0, 1, "R6");
        run_frame(30, 1'b1, 1'b0, 2, "R7");

        // R8 mode change in mid frame
        run_frame(32, 1'b0, 1'b1, 0, "R8");
        run_frame(32, 1'b1, 1'b1, 0, "R8");

        // R9 clock source back to transmit clock after frames
        follow_check("R9");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule